// File: doc/BRIEF.md
# Flash Pulse Retry Sequencer

This block runs the verify-and-retry loop around an external flash pulse engine. A caller supplies an operation code and a start strobe. The sequencer first waits for the engine's error status to read clear. It then fires a pulse and waits for the engine's completion. It records whether the verify flag came back set, and waits again for the status to clear. Based on that result it either fires another pulse or stops.

Erase gets a larger retry budget than program or read. A program operation that first verifies clean is given one more confirming pulse, and its budget grows by one to allow for it. The sequencer refuses any start unless both smart-algorithm enables are on. Every wait is bounded by a polling window, counted in intervals of a configurable number of clock cycles.

When the sequencer finishes, it raises `done_o` for one cycle. At that point `success_o`, a result code and the number of pulses issued are valid. They hold until the next accepted start. A one-cycle strobe marks each retry, so an external watchdog can be serviced.

Top module: `pulse_retry_seq`

## Requirements
- R1: A start with either enable input low, or with op code 3, finishes without a pulse: `done_o` rises one cycle after the start, with result 1 (refused), `success_o` low and `attempts_o` 0.
- R2: Before the first pulse, `err_i` must read low. If it stays high for CLEAR_POLLS polling intervals, the run ends with result 2 and no pulse is issued. If it drops earlier, the run proceeds normally.
- R3: Each pulse is a one-cycle `pulse_start_o`, followed by a wait for `pulse_done_i`. If the engine gives no completion within DONE_POLLS intervals, the run ends at once with result 3, and no further pulse is issued.
- R4: After each completion, `err_i` must fall within CLEAR_POLLS intervals, or the run ends with result 4.
- R5: The value of `err_i` in the completion cycle is the verify result. A failed verify with budget remaining leads to a retry: `retry_o` pulses for one cycle together with the next `pulse_start_o`. No strobe marks the confirming program pulse.
- R6: Op code 0 (erase) has a budget of 45 pulses. Op codes 1 (program) and 2 (read) have 9 pulses each. If a verify fails when the budget is used up, the run ends with result 5 and `attempts_o` equal to the budget.
- R7: For op code 1, the first clean verify triggers one extra pulse and raises the budget by one. This happens once per run. Success follows the next clean verify, so a program run never succeeds with fewer than 2 pulses.
- R8: Erase and read succeed at the first clean verify, with result 0, `success_o` high, and `attempts_o` equal to the number of pulses issued.
- R9: `done_o` is high for exactly one cycle per run. `busy_o` is high from an accepted start until `done_o`. A start seen while busy is ignored.
- R10: After reset the block is idle: `busy_o`, `done_o` and `pulse_start_o` are low and `attempts_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| op_i | input | 2 | 0 erase, 1 program, 2 read, 3 invalid |
| prog_algo_on_i | input | 1 | Smart program algorithm enabled |
| erase_algo_on_i | input | 1 | Smart erase algorithm enabled |
| pulse_done_i | input | 1 | Engine completion strobe |
| err_i | input | 1 | Engine error status is nonzero |
| pulse_start_o | output | 1 | One-cycle pulse request to the engine |
| retry_o | output | 1 | One-cycle strobe on every retry |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| success_o | output | 1 | Run succeeded (valid with done_o) |
| result_o | output | 3 | 0 ok, 1 refused, 2 pre-clear timeout, 3 pulse timeout, 4 post-clear timeout, 5 budget exhausted |
| attempts_o | output | ATT_W | Pulses issued in the current or last run |

## Verification
Faults in the attempt counter or the budget register show up only at the end of a run. They appear as a wrong `attempts_o` or a wrong result code in the `done_o` cycle, so the bench drives runs that end exactly on and one short of each budget. Confirming-pulse bookkeeping that has gone wrong appears within one pulse: `pulse_start_o` either fires once too often or not at all after the first clean program verify. A timer that counts wrongly leaves the run stuck or ends it early, and this is seen as result 2, 3 or 4 at the end of the window.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

    typedef enum logic [1:0] {
        OP_ERASE   = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_READ    = 2'd2,
        OP_BAD     = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RES_OK        = 3'd0,
        RES_REFUSED   = 3'd1,
        RES_PRE_TMO   = 3'd2,
        RES_PULSE_TMO = 3'd3,
        RES_POST_TMO  = 3'd4,
        RES_EXHAUSTED = 3'd5
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECLR,
        ST_FIRE,
        ST_WAIT,
        ST_POSTCLR,
        ST_REPORT
    } st_e;

    typedef struct packed {
        op_e  op;
        logic extra_used;
        logic verify_err;
    } job_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int limit_for(input op_e op, input int lim_erase,
                                     input int lim_prog, input int lim_read);
        case (op)
            OP_ERASE:   return lim_erase;
            OP_PROGRAM: return lim_prog;
            OP_READ:    return lim_read;
            default:    return 0;
        endcase
    endfunction

    function automatic logic start_refused(input logic [1:0] op, input logic prog_on,
                                           input logic erase_on);
        return !(prog_on && erase_on) || (op == 2'd3);
    endfunction

endpackage

// File: rtl/poll_window.sv
module poll_window #(
    parameter int TICK_CYCLES = 4,
    parameter int POLLS       = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    output logic expired_o
);
    localparam int CYC_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int POLL_W = $clog2(POLLS + 1);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(TICK_CYCLES - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLLS);

    logic [CYC_W-1:0]  cyc_q;
    logic [POLL_W-1:0] poll_q;

    assign expired_o = (poll_q == POLL_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cyc_q  <= '0;
            poll_q <= '0;
        end else if (en_i && !expired_o) begin
            if (cyc_q == CYC_LAST) begin
                cyc_q  <= '0;
                poll_q <= poll_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    assert_expiry_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (expired_o && !clr_i) |=> expired_o);

    assert_expiry_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        (!expired_o && !en_i) |=> !expired_o);

endmodule

// File: rtl/attempt_tracker.sv
module attempt_tracker #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] lim_i,
    input  logic         inc_i,
    input  logic         ext_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] lim_o,
    output logic         hit_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= lim_i;
        end else begin
            if (inc_i) cnt_q <= cnt_q + 1'b1;
            if (ext_i) lim_q <= lim_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign lim_o = lim_q;
    assign hit_o = (cnt_q >= lim_q);

    assert_count_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        !load_i |-> (cnt_q <= lim_q));

    assert_no_fire_past_limit_R6: assert property (@(posedge clk) disable iff (rst)
        inc_i |-> (cnt_q < lim_q));

endmodule

// File: rtl/pulse_retry_seq.sv
module pulse_retry_seq
    import pulse_seq_pkg::*;
#(
    parameter int TICK_CYCLES = 4,
    parameter int CLEAR_POLLS = 50,
    parameter int DONE_POLLS  = 1500,
    parameter int ERASE_LIMIT = 45,
    parameter int PROG_LIMIT  = 9,
    parameter int READ_LIMIT  = 9,
    parameter int ATT_W       = $clog2(max3(ERASE_LIMIT, PROG_LIMIT, READ_LIMIT) + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic             prog_algo_on_i,
    input  logic             erase_algo_on_i,
    input  logic             pulse_done_i,
    input  logic             err_i,
    output logic             pulse_start_o,
    output logic             retry_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             success_o,
    output logic [2:0]       result_o,
    output logic [ATT_W-1:0] attempts_o
);
    st_e  st_q, st_d;
    job_t job_q, job_d;
    res_e res_q, res_d;
    logic succ_q, succ_d;
    logic retry_q, retry_d;

    logic             in_clear;
    logic             clr_exp;
    logic             done_exp;
    logic             trk_load, trk_inc, trk_ext;
    logic [ATT_W-1:0] load_lim;
    logic [ATT_W-1:0] att_cnt, att_lim;
    logic             att_hit;
    logic             refuse;

    assign in_clear = (st_q == ST_PRECLR) || (st_q == ST_POSTCLR);
    assign refuse   = start_refused(op_i, prog_algo_on_i, erase_algo_on_i);

    poll_window #(
        .TICK_CYCLES(TICK_CYCLES),
        .POLLS      (CLEAR_POLLS)
    ) u_clear_win (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (!in_clear),
        .en_i     (in_clear && err_i),
        .expired_o(clr_exp)
    );

    poll_window #(
        .TICK_CYCLES(TICK_CYCLES),
        .POLLS      (DONE_POLLS)
    ) u_done_win (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (st_q != ST_WAIT),
        .en_i     (st_q == ST_WAIT),
        .expired_o(done_exp)
    );

    attempt_tracker #(
        .W(ATT_W)
    ) u_tracker (
        .clk   (clk),
        .rst   (rst),
        .load_i(trk_load),
        .lim_i (load_lim),
        .inc_i (trk_inc),
        .ext_i (trk_ext),
        .cnt_o (att_cnt),
        .lim_o (att_lim),
        .hit_o (att_hit)
    );

    always_comb begin
        st_d     = st_q;
        job_d    = job_q;
        res_d    = res_q;
        succ_d   = succ_q;
        retry_d  = 1'b0;
        trk_load = 1'b0;
        trk_inc  = 1'b0;
        trk_ext  = 1'b0;
        load_lim = '0;

        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    trk_load         = 1'b1;
                    job_d.op         = op_e'(op_i);
                    job_d.extra_used = 1'b0;
                    job_d.verify_err = 1'b0;
                    succ_d           = 1'b0;
                    if (refuse) begin
                        res_d = RES_REFUSED;
                        st_d  = ST_REPORT;
                    end else begin
                        load_lim = ATT_W'(limit_for(op_e'(op_i), ERASE_LIMIT,
                                                    PROG_LIMIT, READ_LIMIT));
                        st_d     = ST_PRECLR;
                    end
                end
            end

            ST_PRECLR: begin
                if (!err_i) begin
                    st_d = ST_FIRE;
                end else if (clr_exp) begin
                    res_d = RES_PRE_TMO;
                    st_d  = ST_REPORT;
                end
            end

            ST_FIRE: begin
                trk_inc = 1'b1;
                st_d    = ST_WAIT;
            end

            ST_WAIT: begin
                if (pulse_done_i) begin
                    job_d.verify_err = err_i;
                    st_d             = ST_POSTCLR;
                end else if (done_exp) begin
                    res_d = RES_PULSE_TMO;
                    st_d  = ST_REPORT;
                end
            end

            ST_POSTCLR: begin
                if (!err_i) begin
                    if (!job_q.verify_err) begin
                        if ((job_q.op == OP_PROGRAM) && !job_q.extra_used) begin
                            job_d.extra_used = 1'b1;
                            trk_ext          = 1'b1;
                            st_d             = ST_FIRE;
                        end else begin
                            res_d  = RES_OK;
                            succ_d = 1'b1;
                            st_d   = ST_REPORT;
                        end
                    end else if (!att_hit) begin
                        retry_d = 1'b1;
                        st_d    = ST_FIRE;
                    end else begin
                        res_d = RES_EXHAUSTED;
                        st_d  = ST_REPORT;
                    end
                end else if (clr_exp) begin
                    res_d = RES_POST_TMO;
                    st_d  = ST_REPORT;
                end
            end

            ST_REPORT: st_d = ST_IDLE;

            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            job_q   <= '{op: OP_ERASE, extra_used: 1'b0, verify_err: 1'b0};
            res_q   <= RES_OK;
            succ_q  <= 1'b0;
            retry_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            job_q   <= job_d;
            res_q   <= res_d;
            succ_q  <= succ_d;
            retry_q <= retry_d;
        end
    end

    assign pulse_start_o = (st_q == ST_FIRE);
    assign retry_o       = retry_q;
    assign busy_o        = (st_q != ST_IDLE);
    assign done_o        = (st_q == ST_REPORT);
    assign success_o     = succ_q;
    assign result_o      = res_q;
    assign attempts_o    = att_cnt;

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_refuse_no_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == RES_REFUSED) |-> (attempts_o == '0));

    assert_retry_within_budget_R5: assert property (@(posedge clk) disable iff (rst)
        retry_o |-> (pulse_start_o && (att_cnt < att_lim)));

    assert_exhaust_at_limit_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == RES_EXHAUSTED) |-> (attempts_o == att_lim));

    assert_prog_confirm_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && success_o && job_q.op == OP_PROGRAM) |-> (attempts_o >= ATT_W'(2)));

    assert_timeout_stops_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && done_exp && !pulse_done_i) |=> (done_o && !pulse_start_o));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!pulse_start_o && !retry_o));

    assert_preclear_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PRECLR && err_i) |=> !pulse_start_o);

endmodule

// File: tb/pulse_retry_seq_tb.sv
module pulse_retry_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ATT_W      = 6;
    localparam int NVEC       = 12;

    // Columns: op, failing-prefix length, single bad pulse index,
    //          expected result, expected attempts, expected retry strobes
    localparam int V_OP  [NVEC] = '{0, 2, 1, 1, 1, 1, 2, 0, 0, 2, 1, 1};
    localparam int V_NF  [NVEC] = '{0, 0, 0, 3, 8, 9, 9, 45, 44, 8, 0, 8};
    localparam int V_BAD [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 10};
    localparam int V_RES [NVEC] = '{0, 0, 0, 0, 0, 5, 5, 5, 0, 0, 0, 5};
    localparam int V_ATT [NVEC] = '{1, 1, 2, 5, 10, 9, 9, 45, 45, 9, 3, 10};
    localparam int V_RET [NVEC] = '{0, 0, 0, 3, 8, 8, 8, 44, 44, 8, 1, 8};
    // Row tags: 0 R8, 1 R8, 2 R7, 3 R5, 4 R7, 5 R6, 6 R6, 7 R6, 8 R8, 9 R8, 10 R7, 11 R6
    localparam int V_TAG [NVEC] = '{8, 8, 7, 5, 7, 6, 6, 6, 8, 8, 7, 6};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [1:0] op_i = 2'd0;
    logic prog_algo_on_i = 1'b1;
    logic erase_algo_on_i = 1'b1;
    logic pulse_done_i = 1'b0;
    logic test_err = 1'b0;
    logic eng_err = 1'b0;
    logic err_i;
    logic pulse_start_o, retry_o, busy_o, done_o, success_o;
    logic [2:0] result_o;
    logic [ATT_W-1:0] attempts_o;

    assign err_i = test_err | eng_err;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int retries = 0;
    int dones = 0;
    logic eng_on = 1'b1;
    logic eng_stuck = 1'b0;
    int eng_nfail = 0;
    int eng_badk = 0;
    int eng_k = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_retry_seq u_dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .op_i           (op_i),
        .prog_algo_on_i (prog_algo_on_i),
        .erase_algo_on_i(erase_algo_on_i),
        .pulse_done_i   (pulse_done_i),
        .err_i          (err_i),
        .pulse_start_o  (pulse_start_o),
        .retry_o        (retry_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .success_o      (success_o),
        .result_o       (result_o),
        .attempts_o     (attempts_o)
    );

    // Event monitor
    initial forever begin
        @(negedge clk);
        if (pulse_start_o) pulses++;
        if (retry_o) retries++;
        if (done_o) dones++;
    end

    // Pulse engine model
    initial forever begin
        @(negedge clk);
        if (pulse_start_o && eng_on) begin
            eng_k++;
            repeat (2) @(negedge clk);
            pulse_done_i = 1'b1;
            eng_err = (eng_k <= eng_nfail) || (eng_k == eng_badk);
            @(negedge clk);
            pulse_done_i = 1'b0;
            if (eng_err) begin
                if (eng_stuck) wait (!eng_stuck);
                else repeat (3) @(negedge clk);
                eng_err = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int last_res, last_att, last_succ;

    task automatic run_op(input int op, input int nfail, input int badk);
        int n;
        eng_nfail = nfail;
        eng_badk  = badk;
        eng_k     = 0;
        @(negedge clk);
        pulses = 0; retries = 0; dones = 0;
        op_i = op[1:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        last_res  = int'(result_o);
        last_att  = int'(attempts_o);
        last_succ = int'(success_o);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle after reset
        chk("R10 busy after reset", int'(busy_o), 0);
        chk("R10 done after reset", int'(done_o), 0);
        chk("R10 attempts after reset", int'(attempts_o), 0);
        chk("R10 pulse after reset", int'(pulse_start_o), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_op(V_OP[i], V_NF[i], V_BAD[i]);
            chk($sformatf("R%0d vec%0d result", V_TAG[i], i), last_res, V_RES[i]);
            chk($sformatf("R%0d vec%0d attempts", V_TAG[i], i), last_att, V_ATT[i]);
            chk($sformatf("R%0d vec%0d pulses", V_TAG[i], i), pulses, V_ATT[i]);
            chk($sformatf("R5 vec%0d retries", i), retries, V_RET[i]);
            chk($sformatf("R9 vec%0d done count", i), dones, 1);
            chk($sformatf("R8 vec%0d success", i), last_succ, (V_RES[i] == 0) ? 1 : 0);
        end

        // R1: refusal cases
        prog_algo_on_i = 1'b0;
        run_op(1, 0, 0);
        chk("R1 prog algo off result", last_res, 1);
        chk("R1 prog algo off pulses", pulses, 0);
        chk("R1 prog algo off attempts", last_att, 0);
        prog_algo_on_i = 1'b1;
        erase_algo_on_i = 1'b0;
        run_op(0, 0, 0);
        chk("R1 erase algo off result", last_res, 1);
        chk("R1 erase algo off pulses", pulses, 0);
        erase_algo_on_i = 1'b1;
        run_op(3, 0, 0);
        chk("R1 bad op result", last_res, 1);
        chk("R1 bad op success", last_succ, 0);

        // R2: status clears inside the window
        test_err = 1'b1;
        fork
            begin
                repeat (20) @(negedge clk);
                test_err = 1'b0;
            end
        join_none
        run_op(0, 0, 0);
        chk("R2 late clear result", last_res, 0);
        chk("R2 late clear pulses", pulses, 1);

        // R2: status never clears
        test_err = 1'b1;
        run_op(0, 0, 0);
        chk("R2 stuck status result", last_res, 2);
        chk("R2 stuck status pulses", pulses, 0);
        test_err = 1'b0;

        // R3: engine never completes
        eng_on = 1'b0;
        run_op(2, 0, 0);
        chk("R3 pulse timeout result", last_res, 3);
        chk("R3 pulse timeout pulses", pulses, 1);
        chk("R3 pulse timeout attempts", last_att, 1);
        eng_on = 1'b1;

        // R4: status stuck after a failed pulse
        eng_stuck = 1'b1;
        run_op(0, 1, 0);
        chk("R4 post clear result", last_res, 4);
        chk("R4 post clear pulses", pulses, 1);
        eng_stuck = 1'b0;
        repeat (5) @(negedge clk);

        // R9: start while busy is ignored
        eng_nfail = 2; eng_badk = 0; eng_k = 0;
        @(negedge clk);
        pulses = 0; dones = 0;
        op_i = 2'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 busy during run", int'(busy_o), 1);
        op_i = 2'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (200) @(negedge clk);
        chk("R9 ignored start pulses", pulses, 3);
        chk("R9 ignored start dones", dones, 1);
        chk("R9 idle at end", int'(busy_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule